// File: doc/BRIEF.md
# Sampled Input Capture Buffer with Overrun Flag

This block sits between a digital input sampler and a faster host-side consumer. Each pulse of the sample strobe offers one input word. The word is stored in a first-in first-out buffer unless the buffer is already full. The consumer side is a valid/ready stream that stands in for a bus-master engine. It presents the oldest stored word whenever the buffer holds anything, with no software trigger.

A strobe that finds the buffer full, with no word leaving in that cycle, is thrown away. That event raises a sticky overrun flag. The host reads the flag and clears it with a one-cycle clear pulse. Once a slot frees up, storing resumes at once.

The capacity is the parameter `DEPTH`, and it does not depend on the sample width. The product build sets it to 16384. The default stays smaller so that elaboration remains light. `SAMPLE_W` chooses 8, 16 or 32-bit samples. The host word is always 32 bits wide, and the bits above the sample are zero.

Top module: `sample_capture_fifo`

## Requirements
- R1: After reset, `drn_valid` and `ovr_flag` are both low and the buffer is empty.
- R2: Every strobe that is accepted stores `smp_data`. Stored words leave on the drain port in the order they were accepted, with none lost and none repeated.
- R3: `drn_valid` is high in exactly those cycles in which the buffer holds at least one word. No trigger other than the stored data is needed.
- R4: A word is removed only in a cycle where both `drn_valid` and `drn_ready` are high. While `drn_ready` is low, `drn_data` holds the same word.
- R5: The buffer holds `DEPTH` words. A strobe that arrives while it is full, with no removal in that cycle, is discarded and leaves the stored contents unchanged.
- R6: After at least one word has been removed from a full buffer, the next strobe is stored normally.
- R7: A discarded strobe sets `ovr_flag` in the following cycle. The flag then stays high until it is cleared.
- R8: When `ovr_clr` is asserted in the same cycle as a discarded strobe, `ovr_flag` is high in the following cycle.
- R9: A strobe that arrives while the buffer is full, in a cycle that also removes a word, is stored and does not set `ovr_flag`.
- R10: `drn_data` is 32 bits wide. Its bits at positions `SAMPLE_W` and above are always zero.
- R11: `ovr_clr` asserted in a cycle with no discarded strobe makes `ovr_flag` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one word per high cycle |
| smp_data | input | SAMPLE_W | Sampled input word |
| drn_valid | output | 1 | Drain side holds a word |
| drn_ready | input | 1 | Host accepts the presented word |
| drn_data | output | 32 | Oldest stored word, zero-extended |
| ovr_flag | output | 1 | Sticky overrun status |
| ovr_clr | input | 1 | One-cycle clear of the overrun status |

## Verification
The embedded assertions check the following on every cycle:
- the fill level never exceeds `DEPTH`;
- a discarded strobe leaves the fill level at `DEPTH`;
- the drain word stays stable while it is stalled;
- the upper host bits are zero;
- the flag is set, kept, and cleared in line with the R7, R8 and R11 rules.

Ordering, loss-free transfer and the exact set of words kept across an overrun can only be shown by the bench scenarios. These scenarios fill the buffer completely, strobe into it while it is full, clear the flag in and outside overrun cycles, read and write in the same cycle at full, and drain everything against a scoreboard.

// File: rtl/capfifo_pkg.sv
package capfifo_pkg;

    localparam int HOST_W = 32;

    // Per-cycle transfer decisions shared by the control and flag logic
    typedef struct packed {
        logic push;   // strobe stored this cycle
        logic pop;    // word handed to host this cycle
        logic drop;   // strobe discarded, buffer full
    } xfer_t;

    // Mask with the low w bits set, used for the host-side zero fill
    function automatic logic [HOST_W-1:0] lane_mask(input int unsigned w);
        logic [HOST_W-1:0] m;
        for (int i = 0; i < HOST_W; i++) begin
            m[i] = (i < w);
        end
        return m;
    endfunction

endpackage

// File: rtl/capfifo_ctrl.sv
module capfifo_ctrl
    import capfifo_pkg::*;
#(
    parameter int DEPTH  = 1024,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    input  logic          ready,
    output xfer_t         xf,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          valid
);

    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

    logic [CW-1:0] level;
    logic          full;

    assign full    = (level == FULL_LVL);
    assign valid   = (level != '0);
    assign xf.pop  = valid & ready;
    assign xf.push = strobe & (~full | xf.pop);
    assign xf.drop = strobe & full & ~xf.pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            level   <= '0;
            wr_addr <= '0;
            rd_addr <= '0;
        end else begin
            if (xf.push) wr_addr <= (wr_addr == LAST) ? '0 : wr_addr + 1'b1;
            if (xf.pop)  rd_addr <= (rd_addr == LAST) ? '0 : rd_addr + 1'b1;
            case ({xf.push, xf.pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R5: capacity is never exceeded
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    // R5: a discarded strobe leaves the buffer exactly full
    a_r5_drop_keeps_full: assert property (@(posedge clk) disable iff (rst)
        xf.drop |=> (level == FULL_LVL));

    // R4: no removal while the host stalls
    a_r4_stall_no_loss: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (level >= $past(level)));

    // R9: read plus write at full keeps the buffer full
    a_r9_swap_at_full: assert property (@(posedge clk) disable iff (rst)
        (full && strobe && ready) |=> (level == FULL_LVL));

endmodule

// File: rtl/capfifo_store.sv
module capfifo_store #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/capfifo_ovr.sv
module capfifo_ovr (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= drop | (flag & ~clr);
    end

    // R7: a discarded strobe raises the flag
    a_r7_set_on_drop: assert property (@(posedge clk) disable iff (rst)
        drop |=> flag);

    // R7: the flag stays up without a clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R8: a new overrun wins over a clear
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (drop && clr) |=> flag);

    // R11: a clear without an event drops the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (clr && !drop) |=> !flag);

endmodule

// File: rtl/sample_capture_fifo.sv
module sample_capture_fifo
    import capfifo_pkg::*;
#(
    parameter int DEPTH    = 1024,
    parameter int SAMPLE_W = 16,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                drn_valid,
    input  logic                drn_ready,
    output logic [HOST_W-1:0]   drn_data,
    output logic                ovr_flag,
    input  logic                ovr_clr
);

    xfer_t               xf;
    logic [AW-1:0]       wr_addr;
    logic [AW-1:0]       rd_addr;
    logic [SAMPLE_W-1:0] head;
    logic [HOST_W-1:0]   widened;

    capfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .strobe  (smp_stb),
        .ready   (drn_ready),
        .xf      (xf),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .valid   (drn_valid)
    );

    capfifo_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_store (
        .clk   (clk),
        .we    (xf.push),
        .waddr (wr_addr),
        .wdata (smp_data),
        .raddr (rd_addr),
        .rdata (head)
    );

    capfifo_ovr u_ovr (
        .clk  (clk),
        .rst  (rst),
        .drop (xf.drop),
        .clr  (ovr_clr),
        .flag (ovr_flag)
    );

    generate
        if (SAMPLE_W >= HOST_W) begin : g_full_lane
            assign widened = head[HOST_W-1:0];
        end else begin : g_narrow_lane
            assign widened = {{(HOST_W-SAMPLE_W){1'b0}}, head};
            // R10: host bits above the sample stay zero
            a_r10_zero_fill: assert property (@(posedge clk) disable iff (rst)
                (drn_data & ~lane_mask(SAMPLE_W)) == '0);
        end
    endgenerate

    assign drn_data = widened;

    // R4: a stalled word is held unchanged
    a_r4_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        (drn_valid && !drn_ready) |=> (drn_valid && $stable(drn_data)));

endmodule

// File: tb/sim_sample_capture_fifo.sv
`timescale 1ns/1ps
module sim_sample_capture_fifo;

    localparam int DEPTH = 1024;
    localparam int SW    = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_stb = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          drn_ready = 1'b0;
    logic          ovr_clr = 1'b0;
    logic          drn_valid;
    logic [31:0]   drn_data;
    logic          ovr_flag;

    int checks = 0;
    int fails  = 0;
    int mcount = 0;
    int pops   = 0;
    logic m_ovr = 1'b0;
    logic running = 1'b0;
    logic [31:0] last_word = '0;
    logic [31:0] expq [$];

    always #10 clk = ~clk;

    sample_capture_fifo #(.DEPTH(DEPTH), .SAMPLE_W(SW)) u0 (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_data(smp_data),
        .drn_valid(drn_valid), .drn_ready(drn_ready), .drn_data(drn_data),
        .ovr_flag(ovr_flag), .ovr_clr(ovr_clr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares drained words against the scoreboard
    always @(negedge clk) begin
        if (running) begin
            check(drn_valid == (mcount > 0), "R3 valid", 32'(drn_valid), 32'(mcount > 0));
            if (drn_valid && drn_ready) begin
                logic [31:0] e;
                e = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_DEAD;
                check(drn_data == e, "R2 order", drn_data, e);
                check(drn_data[31:SW] == '0, "R10 zero fill", drn_data, e);
                last_word = drn_data;
                pops++;
            end
        end
    end

    // Driver: applies one cycle of stimulus and updates the reference model
    task automatic step(input logic s, input logic [SW-1:0] d, input logic r,
                        input logic c);
        bit pop, full, acc, drop;
        @(posedge clk); #1;
        smp_stb = s; smp_data = d; drn_ready = r; ovr_clr = c;
        @(negedge clk); #1;
        check(ovr_flag == m_ovr, "R7 flag", 32'(ovr_flag), 32'(m_ovr));
        pop  = (mcount > 0) && r;
        full = (mcount == DEPTH);
        acc  = s && (!full || pop);
        drop = s && full && !pop;
        if (acc) expq.push_back(32'(d));
        mcount = mcount + int'(acc) - int'(pop);
        m_ovr  = drop | (m_ovr & ~c);
    endtask

    initial begin
        #3_000_000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(drn_valid == 1'b0, "R1 valid", 32'(drn_valid), 0);
        check(ovr_flag == 1'b0, "R1 flag", 32'(ovr_flag), 0);
        running = 1'b1;

        // Mixed traffic, alternating ready (R2, R3)
        for (int i = 0; i < 12; i++) step(1'b1, SW'(16'h1100 + i), i[0], 1'b0);
        for (int i = 0; i < 12; i++) step(1'b0, '0, 1'b1, 1'b0);

        // Stall: stored words wait, head word stays put (R4)
        for (int i = 0; i < 3; i++) step(1'b1, SW'(16'h2200 + i), 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1'b0, '0, 1'b0, 1'b0);
            check(drn_data == 32'h2200, "R4 hold", drn_data, 32'h2200);
        end
        for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1, 1'b0);

        // Fill completely, then strobe into the full buffer (R5, R7)
        for (int i = 0; i < DEPTH; i++) step(1'b1, SW'(i * 3 + 7), 1'b0, 1'b0);
        check(drn_valid == 1'b1 && ovr_flag == 1'b0, "R5 full no ovr", 32'(ovr_flag), 0);
        for (int i = 0; i < 3; i++) step(1'b1, SW'(16'hFFF0 + i), 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check(ovr_flag == 1'b1, "R7 set", 32'(ovr_flag), 1);
        step(1'b0, '0, 1'b0, 1'b0);
        check(ovr_flag == 1'b1, "R7 sticky", 32'(ovr_flag), 1);

        // Clear without event (R11)
        step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b0);
        check(ovr_flag == 1'b0, "R11 clear", 32'(ovr_flag), 0);

        // Clear together with a new overrun (R8)
        step(1'b1, 16'hABCD, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b0);
        check(ovr_flag == 1'b1, "R8 set wins", 32'(ovr_flag), 1);
        step(1'b0, '0, 1'b0, 1'b1);

        // Strobe and read together at full (R9)
        step(1'b1, 16'h5A5A, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check(ovr_flag == 1'b0, "R9 no ovr", 32'(ovr_flag), 0);
        check(mcount == DEPTH, "R9 still full", 32'(mcount), 32'(DEPTH));

        // Free one slot, then store again (R6)
        step(1'b0, '0, 1'b1, 1'b0);
        step(1'b1, 16'hBEEF, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check(ovr_flag == 1'b0, "R6 no ovr", 32'(ovr_flag), 0);

        pops = 0;
        while (mcount > 0) step(1'b0, '0, 1'b1, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        check(pops == DEPTH, "R5 drained count", 32'(pops), 32'(DEPTH));
        check(last_word == 32'hBEEF, "R6 resumed word", last_word, 32'hBEEF);
        check(drn_valid == 1'b0, "R3 empty", 32'(drn_valid), 0);
        check(expq.size() == 0, "R2 scoreboard empty", 32'(expq.size()), 0);

        running = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule